// File: doc/BRIEF.md
# Nibble-to-Line 4b/5b Encoder with NRZI Output

This block turns a stream of 4-bit values into a single serial line. Each value arrives with an escape flag and is mapped to a 5-bit line code. The code set has sixteen data codes and one escape code. The chosen code is shifted out one bit per clock, most significant bit first. The bit stream is then NRZI coded: the line level changes for a 1 and holds for a 0. The code set keeps the line from holding one level for too long.

The producer offers a word by raising `in_valid`. The word is taken in the single cycle in every five where `in_ready` is high. If nothing is offered in that cycle, the block sends a fixed data code, set by the `IDLE_NIBBLE` parameter, so the line stays active. That idle code is never the escape code, so the block never creates a start-of-cell command by itself. Command bytes are formed by the producer, which sends escape-flagged words.

Top module: `nibble_line_encoder`

## Requirements
- R1: After reset `in_ready` is low. It is first high in the fifth cycle after reset is released, and from then on it is high for exactly one cycle in every five.
- R2: A data word (escape flag low) with value n is sent as follows. If n[1:0] is not 00, the code is {n[3], 1, n[2], n[1], n[0]}. Otherwise the code is 10101 for n=0000, 00111 for n=0100, 10010 for n=1000 and 10111 for n=1100.
- R3: A word with the escape flag high is sent as 00010, whatever its nibble value.
- R4: Each 5-bit code is sent most significant bit first.
- R5: `line_out` is 0 during and right after reset. On each clock edge it inverts when the bit being sent is 1 and keeps its level when that bit is 0.
- R6: If `in_valid` is low in a cycle where `in_ready` is high, the next code sent is the data code of `IDLE_NIBBLE` (default 0000, so 10101). The first code after reset is also this idle code.
- R7: Values on `in_valid`, `in_nibble` and `in_escape` in cycles where `in_ready` is low have no effect on the line.
- R8: For any mix of data, escape and idle codes, `line_out` never keeps the same level for more than 5 consecutive cycles.
- R9: A word taken at a clock edge shows its first bit on `line_out` at the next clock edge after that one, and one further bit at each edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A word is offered |
| in_nibble | input | 4 | Data value of the offered word |
| in_escape | input | 1 | Offered word is the escape symbol |
| in_ready | output | 1 | The offered word is taken at the end of this cycle |
| line_out | output | 1 | NRZI-coded serial line |

## Verification
The checker watches several rules on every cycle. It checks the one-in-five spacing of `in_ready` against a counter of its own. It checks the NRZI rule of inverting or holding the line according to the current bit. It checks the bound on how long the line holds one level. It also checks the leading bit of the code that follows an escape or an idle slot. Some behaviour can only be shown by the bench's runs. This covers the full value of every code, all sixteen data values and the escape code. It also covers the MSB-first order, the claim that words offered outside the ready cycle are ignored, and the exact alignment between an accepted word and its bits on the line. To show these, the bench decodes the line itself and compares whole codes.

// File: rtl/nibble_line_pkg.sv
package nibble_line_pkg;

    localparam int SYM_W = 5;
    localparam int NIB_W = 4;

    typedef logic [SYM_W-1:0] sym_t;

    typedef struct packed {
        logic             esc;
        logic [NIB_W-1:0] nib;
    } nib_word_t;

    typedef enum logic [1:0] {
        SRC_DATA = 2'd0,
        SRC_ESC  = 2'd1,
        SRC_IDLE = 2'd2
    } sym_src_e;

    localparam sym_t ESC_SYM = 5'b00010;

    function automatic sym_t data_sym(input logic [NIB_W-1:0] n);
        sym_t s;
        case (n)
            4'h0: s = 5'b10101;
            4'h1: s = 5'b01001;
            4'h2: s = 5'b01010;
            4'h3: s = 5'b01011;
            4'h4: s = 5'b00111;
            4'h5: s = 5'b01101;
            4'h6: s = 5'b01110;
            4'h7: s = 5'b01111;
            4'h8: s = 5'b10010;
            4'h9: s = 5'b11001;
            4'hA: s = 5'b11010;
            4'hB: s = 5'b11011;
            4'hC: s = 5'b10111;
            4'hD: s = 5'b11101;
            4'hE: s = 5'b11110;
            default: s = 5'b11111;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/sym_mapper.sv
module sym_mapper
    import nibble_line_pkg::*;
#(
    parameter logic [NIB_W-1:0] IDLE_NIBBLE = '0
) (
    input  logic      valid,
    input  nib_word_t word,
    output sym_t      sym
);
    localparam sym_t IDLE_SYM = data_sym(IDLE_NIBBLE);

    sym_src_e src;

    always_comb begin
        if (!valid)        src = SRC_IDLE;
        else if (word.esc) src = SRC_ESC;
        else               src = SRC_DATA;
    end

    always_comb begin
        case (src)
            SRC_ESC:  sym = ESC_SYM;
            SRC_DATA: sym = data_sym(word.nib);
            default:  sym = IDLE_SYM;
        endcase
    end
endmodule

// File: rtl/sym_shifter.sv
module sym_shifter
    import nibble_line_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  sym_t load_sym,
    input  sym_t reset_sym,
    output logic cur_bit,
    output logic last_bit
);
    localparam int CW = $clog2(SYM_W);
    localparam logic [CW-1:0] LAST_IDX = CW'(SYM_W - 1);

    sym_t          shreg;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= reset_sym;
            cnt   <= '0;
        end else if (cnt == LAST_IDX) begin
            shreg <= load_sym;
            cnt   <= '0;
        end else begin
            shreg <= {shreg[SYM_W-2:0], 1'b0};
            cnt   <= cnt + 1'b1;
        end
    end

    assign cur_bit  = shreg[SYM_W-1];
    assign last_bit = (cnt == LAST_IDX);
endmodule

// File: rtl/nrzi_driver.sv
module nrzi_driver (
    input  logic clk,
    input  logic rst,
    input  logic bit_in,
    output logic line
);
    always_ff @(posedge clk) begin
        if (rst) line <= 1'b0;
        else     line <= line ^ bit_in;
    end
endmodule

// File: rtl/nibble_line_encoder.sv
module nibble_line_encoder
    import nibble_line_pkg::*;
#(
    parameter logic [3:0] IDLE_NIBBLE = 4'h0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       in_valid,
    input  logic [3:0] in_nibble,
    input  logic       in_escape,
    output logic       in_ready,
    output logic       line_out
);
    localparam sym_t IDLE_SYM = data_sym(IDLE_NIBBLE);

    nib_word_t word;
    sym_t      next_sym;
    logic      cur_bit;

    assign word = '{esc: in_escape, nib: in_nibble};

    sym_mapper #(.IDLE_NIBBLE(IDLE_NIBBLE)) u_map (
        .valid (in_valid),
        .word  (word),
        .sym   (next_sym)
    );

    sym_shifter u_shf (
        .clk       (clk),
        .rst       (rst),
        .load_sym  (next_sym),
        .reset_sym (IDLE_SYM),
        .cur_bit   (cur_bit),
        .last_bit  (in_ready)
    );

    nrzi_driver u_nrz (
        .clk    (clk),
        .rst    (rst),
        .bit_in (cur_bit),
        .line   (line_out)
    );
endmodule

// File: rtl/nibble_line_encoder_chk.sv
module nibble_line_encoder_chk
    import nibble_line_pkg::*;
#(
    parameter logic [3:0] IDLE_NIBBLE = 4'h0
) (
    input logic clk,
    input logic rst,
    input logic in_valid,
    input logic in_escape,
    input logic in_ready,
    input logic line_out,
    input logic cur_bit
);
    localparam sym_t IDLE_SYM = data_sym(IDLE_NIBBLE);

    logic [2:0] gap;
    logic [2:0] run;
    logic       prev_line;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap       <= '0;
            run       <= 3'd1;
            prev_line <= 1'b0;
        end else begin
            gap       <= in_ready ? 3'd0 : gap + 3'd1;
            prev_line <= line_out;
            if (line_out != prev_line) run <= 3'd1;
            else if (run != 3'd7)      run <= run + 3'd1;
        end
    end

    p_ready_spacing_r1: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> gap == 3'd4);
    p_ready_due_r1: assert property (@(posedge clk) disable iff (rst)
        gap == 3'd4 |-> in_ready);
    p_escape_lead_r3: assert property (@(posedge clk) disable iff (rst)
        (in_ready && in_valid && in_escape) |=> !cur_bit);
    p_nrzi_toggle_r5: assert property (@(posedge clk) disable iff (rst)
        cur_bit |=> line_out != $past(line_out));
    p_nrzi_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !cur_bit |=> $stable(line_out));
    p_idle_lead_r6: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !in_valid) |=> cur_bit == IDLE_SYM[SYM_W-1]);
    p_run_bound_r8: assert property (@(posedge clk) disable iff (rst)
        run <= 3'd5);
endmodule

bind nibble_line_encoder nibble_line_encoder_chk #(.IDLE_NIBBLE(IDLE_NIBBLE)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_escape (in_escape),
    .in_ready  (in_ready),
    .line_out  (line_out),
    .cur_bit   (cur_bit)
);

// File: tb/test_nibble_line_encoder.sv
module test_nibble_line_encoder;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [3:0] in_nibble = 4'h0;
    logic       in_escape = 1'b0;
    logic       in_ready;
    logic       line_out;

    int checks = 0;
    int errors = 0;

    localparam int NITEMS = 72;

    nibble_line_encoder i_nibble_line_encoder (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_nibble(in_nibble),
        .in_escape(in_escape), .in_ready(in_ready), .line_out(line_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [4:0] exp_code(input logic [3:0] n);
        if (n[1:0] != 2'b00) return {n[3], 1'b1, n[2], n[1], n[0]};
        case (n[3:2])
            2'd0: return 5'b10101;
            2'd1: return 5'b00111;
            2'd2: return 5'b10010;
            default: return 5'b10111;
        endcase
    endfunction

    // kind 0 data, 1 escape, 2 idle
    function automatic void item(input int i, output int kind, output logic [3:0] n);
        int j;
        n = 4'(i * 7 + 3);
        if (i < 16)      begin kind = 0; n = 4'(i); end
        else if (i < 20) kind = 1;
        else if (i < 24) kind = 2;
        else if (i < NITEMS) begin
            j = i - 24;
            case (j % 4)
                0: kind = 1;
                1: begin kind = 0; n = 4'(j); end
                2: kind = 2;
                default: begin kind = 0; n = 4'(15 - (j % 16)); end
            endcase
        end else kind = 2;
    endfunction

    logic [4:0] q[$];
    logic [4:0] rxsr = '0;
    logic [4:0] expv;
    logic       prev_line = 1'b0;
    logic       ready_d = 1'b0;
    bit         run_on = 1'b0;
    int         idx = 0;
    int         gap = 0;
    int         run = 1;
    int         max_run = 0;
    int         cyc = 0;
    int         kind;
    logic [3:0] nv;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (run_on) begin
            // line decode, MSB-first assembly (R4, R5)
            rxsr = {rxsr[3:0], line_out ^ prev_line};
            if (line_out == prev_line) run++;
            else run = 1;
            if (run > max_run) max_run = run;
            prev_line = line_out;
            if (ready_d) begin
                expv = q.pop_front();
                check(rxsr == expv, "R2/R3/R4/R6/R7/R9 code", int'(rxsr), int'(expv));
            end
            // ready spacing R1
            gap++;
            if (in_ready) begin
                check(gap == 5, "R1 ready spacing", gap, 5);
                gap = 0;
            end
            ready_d = in_ready;
            // driver
            if (in_ready) begin
                item(idx, kind, nv);
                idx++;
                in_nibble = nv;
                in_valid  = (kind != 2);
                in_escape = (kind == 1);
                if (kind == 0)      q.push_back(exp_code(nv));
                else if (kind == 1) q.push_back(5'b00010);
                else                q.push_back(5'b10101);
            end else begin
                // noise outside ready cycles, R7
                in_valid  = 1'b1;
                in_escape = cyc[0];
                in_nibble = 4'(cyc * 5);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(line_out == 1'b0, "R5 reset line", int'(line_out), 0);
        check(in_ready == 1'b0, "R1 reset ready", int'(in_ready), 0);
        q.push_back(5'b10101); // first code after reset is idle, R6
        @(posedge clk);
        #1 rst = 1'b0;
        run_on = 1'b1;
        while (idx < NITEMS + 6) @(posedge clk);
        repeat (12) @(posedge clk);
        check(max_run <= 5, "R8 run length", max_run, 5);
        check(idx >= NITEMS, "R1 items taken", idx, NITEMS);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", idx, NITEMS);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule